// File: doc/BRIEF.md
# Masked Packed-Lane Divide Merger

This block wraps an external 16-bit element divider and applies it across a packed vector of up to 32 lanes. When a start strobe arrives, it captures the decoded control bits and the operand buses. From these it works out how many lanes are active, which lanes the write mask selects and which rounding mode applies. It also works out whether every lane takes its divisor from lane 0 of the second operand. It then sends the selected lane pairs one at a time to a shared divider and writes each returned quotient into the matching destination lane.

Lanes that are active but not selected are filled in one of two ways. In zeroing style they are cleared. In merging style they take the value from a separate old-destination bus. Every destination bit above the active vector length is forced to zero. The exception flags returned for the computed lanes are ORed into one status word. A one-cycle done pulse marks the point where the destination and the flags are final.

Top module: `pkdiv_merge`

## Requirements
- R1: `vlen` selects the active lane count: 2'b00 gives 8 lanes (128 bits), 2'b01 gives 16 lanes (256 bits), and 2'b10 or 2'b11 gives 32 lanes (512 bits). Lane i occupies bits [16*i+15:16*i]. After done, every `dst` bit at or above 16 × the lane count reads zero.
- R2: With `mask_en` low, every active lane is computed and the `mask` value has no effect.
- R3: With `mask_en` high, an active lane i is computed only if `mask[i]` is 1. Mask bits at or above the active lane count are ignored.
- R4: In zeroing style (`zero_mode` = 1), an active lane that is not computed reads 0 in `dst`.
- R5: In merging style (`zero_mode` = 0), an active lane that is not computed reads the matching lane of `old_dst`.
- R6: When `src2_mem` and `bcast` are both 1, every request presents lane 0 of `src2` on `div_b`. Otherwise lane i of `src2` is presented for lane i.
- R7: `div_rm` carries `rc_embed` only when the length is 512 bits, `src2_mem` is 0 and `bcast` is 1. In every other case it carries `rc_csr`.
- R8: Computed lanes are requested one at a time in ascending index order, and lanes that are not computed are never requested. `div_idx` names the lane. `div_req` stays high with stable `div_idx`, `div_a`, `div_b` and `div_rm` until `div_valid` is sampled high at a clock edge, and the result is taken at that edge.
- R9: `flags` is cleared on start. It then accumulates the OR of `div_flags` over the computed lanes only.
- R10: `done` is a single-cycle pulse, raised one clock after the last result is taken, or one clock after start when no lane is computed. `busy` is high from the clock after start until done. A start strobe while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `div_req`, `dst` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| vlen | input | 2 | Vector length select |
| mask_en | input | 1 | Write mask in use |
| zero_mode | input | 1 | 1 = zeroing style, 0 = merging style |
| src2_mem | input | 1 | Second operand comes from memory |
| bcast | input | 1 | Broadcast / embedded-rounding control bit |
| rc_embed | input | 2 | Rounding mode embedded in the instruction |
| rc_csr | input | 2 | Rounding mode from the control register |
| mask | input | 32 | Per-lane write mask |
| src1 | input | 512 | Dividend lanes |
| src2 | input | 512 | Divisor lanes |
| old_dst | input | 512 | Previous destination, source for merging |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dst | output | 512 | Destination vector |
| flags | output | 5 | ORed exception flags of computed lanes |
| div_req | output | 1 | Request to the divider |
| div_idx | output | 5 | Lane index of the current request |
| div_a | output | 16 | Dividend for the divider |
| div_b | output | 16 | Divisor for the divider |
| div_rm | output | 2 | Rounding mode for the divider |
| div_valid | input | 1 | Divider result valid |
| div_res | input | 16 | Divider quotient |
| div_flags | input | 5 | Divider exception flags |

## Verification
The embedded checks assume that the divider raises `div_valid` only while `div_req` is high, and one of them guards this assumption. The bench's divider model follows the rule by construction: it answers only a pending request, after a random delay of 0 to 2 cycles, and drops `div_valid` in the cycle after each result is accepted. All control bits, including the reserved length code 2'b11, are drawn from a fixed seed. Directed cases cover an empty mask, mask bits that lie only above the active length, and a start strobe issued mid-operation.

// File: rtl/pkdiv_pkg.sv
package pkdiv_pkg;

   // vector length select codes
   localparam logic [1:0] VL_QUARTER = 2'b00;
   localparam logic [1:0] VL_HALF    = 2'b01;

   // active lane count for a length code, out of max_lanes
   function automatic int lanes_for(input logic [1:0] vl, input int max_lanes);
      case (vl)
         VL_QUARTER: return max_lanes / 4;
         VL_HALF:    return max_lanes / 2;
         default:    return max_lanes;
      endcase
   endfunction

endpackage

// File: rtl/pkdiv_ctl_sel.sv
module pkdiv_ctl_sel #(
   parameter int MAX_LANES = 32,
   parameter int RM_W      = 2
) (
   input  logic [1:0]           vlen,
   input  logic                 mask_en,
   input  logic [MAX_LANES-1:0] mask,
   input  logic                 src2_mem,
   input  logic                 bcast,
   input  logic [RM_W-1:0]      rc_embed,
   input  logic [RM_W-1:0]      rc_csr,
   output logic [MAX_LANES-1:0] active,
   output logic [MAX_LANES-1:0] cmask,
   output logic [RM_W-1:0]      rm,
   output logic                 use_b0
);
   import pkdiv_pkg::*;

   int lane_cnt;
   always_comb lane_cnt = lanes_for(vlen, MAX_LANES);

   for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
      assign active[i] = (i < lane_cnt);
      assign cmask[i]  = active[i] & (mask[i] | ~mask_en);
   end

   // embedded rounding only at full length with a register divisor
   assign rm     = (vlen[1] && !src2_mem && bcast) ? rc_embed : rc_csr;
   assign use_b0 = src2_mem & bcast;

endmodule

// File: rtl/pkdiv_pick.sv
module pkdiv_pick #(
   parameter int MAX_LANES = 32,
   localparam int IDX_W    = $clog2(MAX_LANES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAX_LANES-1:0] pend,
   output logic                 any,
   output logic [IDX_W-1:0]     idx
);

   assign any = |pend;

   always_comb begin
      idx = '0;
      for (int i = MAX_LANES - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end

   // R8
   pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> pend[idx]);

endmodule

// File: rtl/pkdiv_merge.sv
module pkdiv_merge #(
   parameter int LANE_W    = 16,
   parameter int MAX_LANES = 32,
   parameter int FLAG_W    = 5,
   parameter int RM_W      = 2,
   localparam int DW       = LANE_W * MAX_LANES,
   localparam int IDX_W    = $clog2(MAX_LANES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           vlen,
   input  logic                 mask_en,
   input  logic                 zero_mode,
   input  logic                 src2_mem,
   input  logic                 bcast,
   input  logic [RM_W-1:0]      rc_embed,
   input  logic [RM_W-1:0]      rc_csr,
   input  logic [MAX_LANES-1:0] mask,
   input  logic [DW-1:0]        src1,
   input  logic [DW-1:0]        src2,
   input  logic [DW-1:0]        old_dst,
   output logic                 busy,
   output logic                 done,
   output logic [DW-1:0]        dst,
   output logic [FLAG_W-1:0]    flags,
   output logic                 div_req,
   output logic [IDX_W-1:0]     div_idx,
   output logic [LANE_W-1:0]    div_a,
   output logic [LANE_W-1:0]    div_b,
   output logic [RM_W-1:0]      div_rm,
   input  logic                 div_valid,
   input  logic [LANE_W-1:0]    div_res,
   input  logic [FLAG_W-1:0]    div_flags
);

   if (MAX_LANES % 4 != 0 || MAX_LANES < 4) begin : g_bad_lanes
      $error("MAX_LANES must be a multiple of 4");
   end
   if (LANE_W < 1 || FLAG_W < 1 || RM_W < 1) begin : g_bad_width
      $error("lane, flag and rounding widths must be positive");
   end

   logic [MAX_LANES-1:0] active, cmask, pend_q;
   logic [RM_W-1:0]      rm_sel, rm_q;
   logic                 use_b0, b0_q, busy_q, done_q, any_pend;
   logic [DW-1:0]        a_q, b_q, dst_q, dst_init;
   logic [FLAG_W-1:0]    flg_q;
   logic [IDX_W-1:0]     pick_idx;

   pkdiv_ctl_sel #(.MAX_LANES(MAX_LANES), .RM_W(RM_W)) u_sel (
      .vlen(vlen), .mask_en(mask_en), .mask(mask), .src2_mem(src2_mem),
      .bcast(bcast), .rc_embed(rc_embed), .rc_csr(rc_csr),
      .active(active), .cmask(cmask), .rm(rm_sel), .use_b0(use_b0));

   pkdiv_pick #(.MAX_LANES(MAX_LANES)) u_pick (
      .clk(clk), .rst_n(rst_n), .pend(pend_q), .any(any_pend), .idx(pick_idx));

   // fill for lanes that will not be computed: merge, zero, or above length
   for (genvar i = 0; i < MAX_LANES; i++) begin : g_init
      assign dst_init[i*LANE_W +: LANE_W] =
         (active[i] && !cmask[i] && !zero_mode) ? old_dst[i*LANE_W +: LANE_W]
                                                : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pend_q <= '0;
         rm_q   <= '0;
         b0_q   <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         dst_q  <= '0;
         flg_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               pend_q <= cmask;
               rm_q   <= rm_sel;
               b0_q   <= use_b0;
               a_q    <= src1;
               b_q    <= src2;
               dst_q  <= dst_init;
               flg_q  <= '0;
            end
         end else if (!any_pend) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else if (div_valid) begin
            dst_q[pick_idx*LANE_W +: LANE_W] <= div_res;
            flg_q            <= flg_q | div_flags;
            pend_q[pick_idx] <= 1'b0;
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign dst     = dst_q;
   assign flags   = flg_q;
   assign div_req = busy_q & any_pend;
   assign div_idx = pick_idx;
   assign div_a   = a_q[pick_idx*LANE_W +: LANE_W];
   assign div_b   = b0_q ? b_q[LANE_W-1:0] : b_q[pick_idx*LANE_W +: LANE_W];
   assign div_rm  = rm_q;

   // input rule: the divider answers only a pending request
   valid_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_valid |-> div_req);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_req && !div_valid |=> div_req && $stable(div_idx) && $stable(div_a)
                                && $stable(div_b) && $stable(div_rm));

   // R8
   idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_req && div_valid |=> !div_req || (div_idx > $past(div_idx)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !div_req);

   // R9
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !div_valid && !$rose(busy) |=> $stable(flags));

endmodule

// File: tb/pkdiv_merge_tb.sv
module pkdiv_merge_tb;
   localparam int LW = 16, NL = 32, FW = 5, DW = LW * NL;

   logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [1:0]    vlen = '0, rc_embed = '0, rc_csr = '0;
   logic          mask_en = 1'b0, zero_mode = 1'b0, src2_mem = 1'b0, bcast = 1'b0;
   logic [NL-1:0] mask = '0;
   logic [DW-1:0] src1 = '0, src2 = '0, old_dst = '0;
   logic          busy, done, div_req, div_valid = 1'b0;
   logic [DW-1:0] dst;
   logic [FW-1:0] flags, div_flags = '0;
   logic [4:0]    div_idx;
   logic [LW-1:0] div_a, div_b, div_res = '0;
   logic [1:0]    div_rm;

   int total = 0, bad = 0, wait_cnt = 0, log_n = 0;
   logic [4:0]    log_idx[NL];
   logic [LW-1:0] log_a[NL], log_b[NL];
   logic [1:0]    log_rm[NL];

   pkdiv_merge u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask_en(mask_en),
      .zero_mode(zero_mode), .src2_mem(src2_mem), .bcast(bcast),
      .rc_embed(rc_embed), .rc_csr(rc_csr), .mask(mask), .src1(src1),
      .src2(src2), .old_dst(old_dst), .busy(busy), .done(done), .dst(dst),
      .flags(flags), .div_req(div_req), .div_idx(div_idx), .div_a(div_a),
      .div_b(div_b), .div_rm(div_rm), .div_valid(div_valid),
      .div_res(div_res), .div_flags(div_flags));

   always #10 clk = ~clk;

   function automatic logic [LW-1:0] qmodel(logic [LW-1:0] a, logic [LW-1:0] b, logic [1:0] rm);
      return a ^ {b[7:0], b[15:8]} ^ {14'd0, rm} ^ 16'h5a00;
   endfunction

   function automatic logic [FW-1:0] fmodel(logic [LW-1:0] a, logic [LW-1:0] b, logic [1:0] rm);
      return a[4:0] ^ b[9:5] ^ {3'b0, rm};
   endfunction

   // divider model: answers a pending request after 0..2 idle cycles
   always @(negedge clk) begin
      if (div_valid) begin
         div_valid = 1'b0;
      end else if (rst_n && div_req) begin
         if (wait_cnt == 0) begin
            div_valid = 1'b1;
            div_res   = qmodel(div_a, div_b, div_rm);
            div_flags = fmodel(div_a, div_b, div_rm);
            if (log_n < NL) begin
               log_idx[log_n] = div_idx; log_a[log_n] = div_a;
               log_b[log_n] = div_b;     log_rm[log_n] = div_rm;
            end
            log_n = log_n + 1;
            wait_cnt = int'($urandom % 3);
         end else begin
            wait_cnt = wait_cnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] vl, input bit men, input bit zm,
                         input bit mem, input bit bc, input logic [1:0] rce,
                         input logic [1:0] rcc, input logic [NL-1:0] m,
                         input logic [DW-1:0] s1, input logic [DW-1:0] s2,
                         input logic [DW-1:0] od, input bit poke);
      int lanes, n, cyc;
      logic [DW-1:0] exp_dst;
      logic [FW-1:0] exp_flg;
      logic [1:0]    erm;
      logic [LW-1:0] eb;
      bit ord_ok;
      lanes = (vl == 2'b00) ? NL / 4 : (vl == 2'b01) ? NL / 2 : NL;
      erm = (vl[1] && !mem && bc) ? rce : rcc;                  // R7
      exp_dst = '0; exp_flg = '0; n = 0; ord_ok = 1'b1;
      @(negedge clk);
      log_n = 0;
      vlen = vl; mask_en = men; zero_mode = zm; src2_mem = mem; bcast = bc;
      rc_embed = rce; rc_csr = rcc; mask = m; src1 = s1; src2 = s2; old_dst = od;
      for (int i = 0; i < lanes; i++) begin
         if (!men || m[i]) begin
            eb = (mem && bc) ? s2[LW-1:0] : s2[i*LW +: LW];     // R6
            exp_dst[i*LW +: LW] = qmodel(s1[i*LW +: LW], eb, erm);
            exp_flg = exp_flg | fmodel(s1[i*LW +: LW], eb, erm);
            if (n < NL && (log_idx[n] !== 5'(i) || log_a[n] !== s1[i*LW +: LW]
                || log_b[n] !== eb || log_rm[n] !== erm)) ord_ok = 1'b0;
            n++;
         end else if (!zm) begin
            exp_dst[i*LW +: LW] = od[i*LW +: LW];               // R5
         end
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         chk(busy === 1'b1, "R10", "busy during op", DW'(busy), DW'(1));
         src1 = ~s1; mask = ~m; start = 1'b1;                   // R10 ignored
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (done !== 1'b1 && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done === 1'b1, "R10", "done seen", DW'(done), DW'(1));
      chk(busy === 1'b0, "R10", "idle at done", DW'(busy), DW'(0));
      chk(dst === exp_dst, "R1 R2 R3 R4 R5", "dst", dst, exp_dst);
      chk(dst >> (lanes * LW) === '0, "R1", "upper clear", dst >> (lanes * LW), '0);
      chk(flags === exp_flg, "R9", "flags", DW'(flags), DW'(exp_flg));
      chk(log_n == n, "R8", "request count", DW'(log_n), DW'(n));
      // log entries recheck after the run completes
      ord_ok = 1'b1; n = 0;
      for (int i = 0; i < lanes; i++) begin
         if (!men || m[i]) begin
            eb = (mem && bc) ? s2[LW-1:0] : s2[i*LW +: LW];
            if (n < NL && (log_idx[n] !== 5'(i) || log_a[n] !== s1[i*LW +: LW]
                || log_b[n] !== eb || log_rm[n] !== erm)) ord_ok = 1'b0;
            n++;
         end
      end
      chk(ord_ok, "R6 R7 R8", "request order/operands", DW'(ord_ok), DW'(1));
      @(negedge clk);
      chk(done === 1'b0, "R10", "done one cycle", DW'(done), DW'(0));
   endtask

   function automatic logic [DW-1:0] rnd_vec();
      logic [DW-1:0] v;
      for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      #(20 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy === 1'b0 && done === 1'b0 && div_req === 1'b0, "R11", "ctl reset",
          DW'({busy, done, div_req}), '0);
      chk(dst === '0, "R11", "dst reset", dst, '0);
      chk(flags === '0, "R11", "flags reset", DW'(flags), '0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 full length, no mask, embedded rounding (R7)
      run_op(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd1, 32'h0, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      // R3 mask bits only above 8 lanes: nothing computed, merge kept
      run_op(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 32'hFFFF_FF00, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      // R4 empty mask, zeroing
      run_op(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 32'h0, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      // R6 broadcast from memory, R7 rounding stays csr
      run_op(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 2'd2, 32'hA5C3_0F11, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      // R7 bcast at 256 bits with register divisor: csr rounding
      run_op(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 2'd0, 32'h0, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      // R10 start while busy ignored
      run_op(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 32'h0, rnd_vec(), rnd_vec(), rnd_vec(), 1'b1);
      for (int k = 0; k < 40; k++) begin
         run_op(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 2'($urandom), 2'($urandom), $urandom,
                rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule